// File: doc/BRIEF.md
# Unaligned Partial-Word Store Aligner

This block prepares one half of a 32-bit word store aimed at an arbitrary byte address. A request supplies a 64-bit base value, a signed 16-bit displacement, a 64-bit source value and a side select. The side select picks the upper-part store or the lower-part store. The block adds the sign-extended displacement to the base to form the byte address. From that address it derives the word-aligned address, the lanes to be written in that aligned word, and the write data rotated into those lanes.

Memory uses big-endian lane numbering: lane 0 is bits 31:24 of the write data. A word that straddles two aligned words is written with two requests at the same word address. The upper-part store writes the high-order bytes that land in the first aligned word. The lower-part store writes the low-order bytes that land in the second. All results are registered, so they appear one clock after the request.

Top module: `store_aligner`

## Requirements
- R1: The byte address is the base plus the 16-bit displacement sign-extended to 64 bits, modulo 2^64. The output address equals that byte address with bits 1:0 forced to zero.
- R2: For an upper-part store (side = 0) with address bits 1:0 equal to k, enable bits k..3 are set and all others are clear. Enable bit i maps to lane i, and lane i is write-data bits 31-8i downto 24-8i.
- R3: For an upper-part store, lane k+j carries source byte 3-j for j = 0..3-k. Source byte n is source bits 8n+7:8n. Lanes that are not enabled carry zero.
- R4: For a lower-part store (side = 1) with address bits 1:0 equal to k, enable bits 0..k are set and all others are clear.
- R5: For a lower-part store, lane j carries source byte k-j for j = 0..k. Lanes that are not enabled carry zero.
- R6: Only source bits 31:0 affect the outputs. Bits 63:32 have no effect.
- R7: An upper-part store at k = 0 and a lower-part store at k = 3 each set all four enables and carry source bits 31:0 unchanged.
- R8: The output valid strobe equals the input valid strobe delayed by one clock. A synchronous reset clears it. Address, enables and data update only on cycles with a valid request and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqSide | input | 1 | 0 = upper-part store, 1 = lower-part store |
| reqBase | input | 64 | Base value |
| reqDisp | input | 16 | Signed displacement |
| reqSrc | input | 64 | Source value; only bits 31:0 are used |
| wrValid | output | 1 | Result strobe, one clock after reqValid |
| wrAddr | output | 64 | Word-aligned address |
| wrByteEn | output | 4 | Lane enables; bit i enables lane i |
| wrData | output | 32 | Lane-aligned write data |

## Verification
Any error in the lane-offset decode or the side select shows up in the very next result. It appears as an enable mask or a byte arrangement that cannot occur for that side and offset. A carry or sign-extension fault shows up in the next output address. It is visible when the displacement is negative or when the add carries across the 32-bit boundary. A fault in the valid or hold logic appears one clock after a request, or on an idle cycle, as a strobe or held value that does not match.

// File: rtl/store_aligner_pkg.sv
package store_aligner_pkg;
  localparam int ADDR_W = 64;
  localparam int DISP_W = 16;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int OFS_W  = $clog2(LANES);

  typedef struct packed {
    logic load;
    logic side;
  } ctrl_t;
endpackage

// File: rtl/store_aligner_ctrl.sv
module store_aligner_ctrl
  import store_aligner_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  reqValid,
  input  logic  reqSide,
  output ctrl_t ctrl,
  output logic  wrValid
);
  assign ctrl.load = reqValid;
  assign ctrl.side = reqSide;

  always_ff @(posedge clk) begin
    if (rst) wrValid <= 1'b0;
    else     wrValid <= reqValid;
  end

  p_valid_delay_r8: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> wrValid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !wrValid);
endmodule

// File: rtl/store_aligner_dp.sv
module store_aligner_dp
  import store_aligner_pkg::*;
(
  input  logic              clk,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [DISP_W-1:0] reqDisp,
  input  logic [ADDR_W-1:0] reqSrc,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrByteEn,
  output logic [WORD_W-1:0] wrData
);
  logic [ADDR_W-1:0] effAddr;
  logic [OFS_W-1:0]  laneOfs;
  logic [LANES-1:0]  enNext;
  logic [WORD_W-1:0] dataNext;
  logic [WORD_W-1:0] srcWord;

  assign effAddr = reqBase + {{(ADDR_W-DISP_W){reqDisp[DISP_W-1]}}, reqDisp};
  assign laneOfs = effAddr[OFS_W-1:0];
  assign srcWord = reqSrc[WORD_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (!ctrl.side) begin
        enNext[l] = (l >= int'(laneOfs));
        dataNext[WORD_W-1-8*l -: 8] = enNext[l]
          ? srcWord[8*(LANES-1-(l-int'(laneOfs))) +: 8] : 8'h00;
      end else begin
        enNext[l] = (l <= int'(laneOfs));
        dataNext[WORD_W-1-8*l -: 8] = enNext[l]
          ? srcWord[8*(int'(laneOfs)-l) +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      wrAddr   <= {effAddr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      wrByteEn <= enNext;
      wrData   <= dataNext;
    end
  end

  p_addr_aligned_r1: assert property (@(posedge clk)
    ctrl.load |=> wrAddr[OFS_W-1:0] == '0);
  p_upper_msb_r2: assert property (@(posedge clk)
    (ctrl.load && !ctrl.side) |=> wrByteEn[LANES-1]);
  p_lower_lsb_r4: assert property (@(posedge clk)
    (ctrl.load && ctrl.side) |=> wrByteEn[0]);
  p_mask_nonzero_r3: assert property (@(posedge clk)
    ctrl.load |=> wrByteEn != '0);
  p_hold_r8: assert property (@(posedge clk)
    !ctrl.load |=> $stable(wrByteEn) && $stable(wrData));
endmodule

// File: rtl/store_aligner.sv
module store_aligner
  import store_aligner_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqSide,
  input  logic [63:0] reqBase,
  input  logic [15:0] reqDisp,
  input  logic [63:0] reqSrc,
  output logic        wrValid,
  output logic [63:0] wrAddr,
  output logic [3:0]  wrByteEn,
  output logic [31:0] wrData
);
  ctrl_t ctrl;

  store_aligner_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqSide(reqSide),
    .ctrl(ctrl), .wrValid(wrValid)
  );

  store_aligner_dp u_dp (
    .clk(clk), .ctrl(ctrl), .reqBase(reqBase), .reqDisp(reqDisp),
    .reqSrc(reqSrc), .wrAddr(wrAddr), .wrByteEn(wrByteEn), .wrData(wrData)
  );
endmodule

// File: tb/store_aligner_tb.sv
module store_aligner_tb;
  logic        clk = 0;
  logic        rst;
  logic        reqValid, reqSide;
  logic [63:0] reqBase, reqSrc;
  logic [15:0] reqDisp;
  logic        wrValid;
  logic [63:0] wrAddr;
  logic [3:0]  wrByteEn;
  logic [31:0] wrData;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  store_aligner u_dut (.*);

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [63:0] expAddr(logic [63:0] b, logic [15:0] d);
    logic [63:0] e = b + {{48{d[15]}}, d};
    return {e[63:2], 2'b00};
  endfunction

  function automatic logic [3:0] expEn(logic side, logic [1:0] k);
    logic [3:0] m = 0;
    for (int i = 0; i < 4; i++)
      m[i] = side ? (i <= k) : (i >= k);
    return m;
  endfunction

  function automatic logic [31:0] expData(logic side, logic [1:0] k, logic [31:0] s);
    logic [31:0] d = 0;
    for (int i = 0; i < 4; i++) begin
      int n;
      if (side) begin
        if (i > k) continue;
        n = k - i;
      end else begin
        if (i < k) continue;
        n = 3 - (i - k);
      end
      d[31-8*i -: 8] = s[8*n +: 8];
    end
    return d;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic side, logic [63:0] b, logic [15:0] d, logic [63:0] s);
    logic [63:0] e;
    logic [1:0]  k;
    e = b + {{48{d[15]}}, d};
    k = e[1:0];
    reqValid = 1; reqSide = side; reqBase = b; reqDisp = d; reqSrc = s;
    @(posedge clk); #1;
    reqValid = 0;
    chk("R8 valid", {63'b0, wrValid}, 64'd1);
    chk("R1 addr", wrAddr, expAddr(b, d));
    chk(side ? "R4 enables" : "R2 enables", {60'b0, wrByteEn}, {60'b0, expEn(side, k)});
    chk(side ? "R5 data" : "R3 data", {32'b0, wrData}, {32'b0, expData(side, k, s[31:0])});
  endtask

  initial begin
    logic [31:0] hd;
    logic [3:0]  he;
    rst = 1; reqValid = 0; reqSide = 0; reqBase = 0; reqDisp = 0; reqSrc = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset valid", {63'b0, wrValid}, 64'd0);
    rst = 0;
    // R7: full-word cases
    apply(0, 64'h1000, 16'h0000, 64'hFFFF_FFFF_A1B2_C3D4);
    chk("R7 upper full", {32'b0, wrData}, 64'hA1B2_C3D4);
    apply(1, 64'h1000, 16'h0003, 64'h0000_0000_A1B2_C3D4);
    chk("R7 lower full", {32'b0, wrData}, 64'hA1B2_C3D4);
    // R2/R3 and R4/R5: every offset
    for (int k = 0; k < 4; k++) begin
      apply(0, 64'h2000 + k, 16'h0000, 64'h1122_3344);
      apply(1, 64'h2000, k[15:0], 64'h1122_3344);
    end
    // R1: negative displacement and a carry into the upper half
    apply(0, 64'h0000_0000_0000_0001, 16'hFFFE, 64'h55);
    apply(1, 64'h0000_0000_FFFF_FFFE, 16'h0005, 64'h99);
    // R6: upper source bits ignored
    apply(0, 64'h3001, 0, 64'h0000_0000_CAFE_BABE);
    hd = wrData;
    apply(0, 64'h3001, 0, 64'hDEAD_BEEF_CAFE_BABE);
    chk("R6 upper src ignored", {32'b0, wrData}, {32'b0, hd});
    // R8: idle cycle holds outputs and drops the strobe
    hd = wrData; he = wrByteEn;
    reqBase = 64'h7; reqSrc = 64'h1; reqSide = 1;
    @(posedge clk); #1;
    chk("R8 idle valid", {63'b0, wrValid}, 0);
    chk("R8 hold data", {32'b0, wrData}, {32'b0, hd});
    chk("R8 hold en", {60'b0, wrByteEn}, {60'b0, he});
    // Random requests from a fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++)
      apply($urandom % 2, {$urandom, $urandom}, $urandom, {$urandom, $urandom});
    // R8: reset clears the strobe
    reqValid = 1; rst = 1;
    @(posedge clk); #1;
    chk("R8 reset clears", {63'b0, wrValid}, 0);
    rst = 0; reqValid = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule